// File: doc/BRIEF.md
# Supply and Bus-Activity Reset Supervisor

This block drives a system reset from two causes. The first is a supply-low flag from an analog comparator. While the flag is set, reset is asserted. Once the flag clears, reset stays asserted for a fixed hold time before it releases. The second cause is a watchdog timer. The watchdog has no dedicated kick input. Instead, it watches a two-wire serial bus and restarts on every START condition, which is SDA falling while SCL is high. If no START arrives within the selected timeout, the block issues a reset that lasts for the same hold time.

A three-state machine sequences the reset:

- `ST_LOW`: the supply is below threshold.
- `ST_HOLD`: the hold time is being counted.
- `ST_RUN`: reset is released and the watchdog may count.

The transitions are:

- `LOW_TO_HOLD`: the supply flag clears.
- `HOLD_TO_RUN`: the hold count completes.
- `RUN_TO_HOLD`: the watchdog bites.
- `ANY_TO_LOW`: the supply flag is set.

The logic reset `rst_n` puts the machine in `ST_HOLD`, which models power-up. The hold time and the three timeout lengths are clock-cycle parameters. A parameter chooses an active-high or an active-low reset output.

Top module: `supv_reset_wdt`

## Requirements
- R1: When `supply_low` is 1 at a rising clock edge, reset is asserted after that edge and stays asserted while the flag remains 1.
- R2: When `supply_low` returns to 0, reset releases exactly HOLD_CYC+1 rising edges after the first edge that sees the flag at 0.
- R3: While `rst_n` is 0, reset is asserted. After `rst_n` rises with the supply good, reset releases at the HOLD_CYC-th rising edge. If the supply is low at power-up, R2 timing applies from recovery.
- R4: A falling `sda_i` while `scl_i` is 1 is a START. Both lines pass two synchronizer flops. A START restarts the watchdog, so with no further START the watchdog reset asserts LIMIT+3 rising edges after the edge at which `sda_i` falls.
- R5: Changes of `sda_i` while `scl_i` is 0 do not restart the watchdog.
- R6: The `wd_sel` codes are 0 = disabled, 1 = WD_SHORT, 2 = WD_MED and 3 = WD_LONG cycles. With no START, the watchdog reset asserts at the LIMIT-th rising edge after reset releases.
- R7: With `wd_en` at 0, the watchdog never asserts reset.
- R8: The watchdog counter is held at zero while reset is asserted. A watchdog reset lasts HOLD_CYC cycles, after which the watchdog counts again from zero.
- R9: A change of `wd_sel` or `wd_en` restarts the watchdog. The next bite comes LIMIT+1 rising edges after the edge that first sees the new value.
- R10: With ACT_HIGH = 1, `rst_o` is 1 when reset is asserted. With ACT_HIGH = 0, `rst_o` is 0 when reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset (power-up) |
| supply_low | input | 1 | Comparator flag, 1 = supply below threshold |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Timeout select code |
| rst_o | output | 1 | System reset, polarity set by ACT_HIGH |

## Verification
A wrong internal state shows up as a reset edge that comes too early or too late, so every check measures the number of edges between a stimulus and a reset transition. These are the possible faults and what they show:

- A hold counter that is off by one shifts the release by a cycle, and this is seen on the first release after power-up.
- A watchdog counter that is not cleared during reset makes the first bite after a release come early.
- A START detector that fires on the wrong line combination produces either a missing reset or a reset during random kicking, within one timeout period.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } supv_st_e;

    typedef logic [1:0] wd_sel_t;

    localparam wd_sel_t SEL_OFF   = 2'd0;
    localparam wd_sel_t SEL_SHORT = 2'd1;
    localparam wd_sel_t SEL_MED   = 2'd2;
    localparam wd_sel_t SEL_LONG  = 2'd3;
endpackage

// File: rtl/supv_start_det.sv
module supv_start_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_sh[TOP];
    end

    always_comb start_o = scl_sh[TOP] & sda_prev & ~sda_sh[TOP];

    // R5: a START needs the line samples to have seen SDA high, then low
    AST_START_IS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o) else $error("double start");   // R5
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
    import supv_pkg::*;
#(
    parameter int WD_SHORT = 25_000_000,
    parameter int WD_MED   = 100_000_000,
    parameter int WD_LONG  = 350_000_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    arm,
    input  logic    wd_en,
    input  wd_sel_t wd_sel,
    input  logic    kick,
    output logic    bite
);
    localparam int CW = $clog2(WD_LONG + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          en_q;
    wd_sel_t       sel_q;
    logic          cfg_chg;
    logic          run;

    always_comb begin
        unique case (wd_sel)
            SEL_SHORT: lim = CW'(WD_SHORT);
            SEL_MED:   lim = CW'(WD_MED);
            SEL_LONG:  lim = CW'(WD_LONG);
            default:   lim = '0;
        endcase
    end

    always_comb begin
        cfg_chg = (wd_sel != sel_q) || (wd_en != en_q);
        run     = arm && wd_en && (wd_sel != SEL_OFF) && !kick && !cfg_chg;
        bite    = run && (cnt == lim - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            en_q  <= 1'b0;
            sel_q <= SEL_OFF;
        end else begin
            en_q  <= wd_en;
            sel_q <= wd_sel;
            if (run && !bite) cnt <= cnt + CW'(1);
            else              cnt <= '0;
        end
    end

    AST_CLR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cnt == '0)) else $error("count not held");   // R8
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0)) else $error("kick ignored");     // R4
    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel != $past(wd_sel)) |=> (cnt == '0)) else $error("cfg"); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(WD_LONG)) else $error("overflow");           // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (cnt == '0)) else $error("disabled counting"); // R7
endmodule

// File: rtl/supv_reset_wdt.sv
module supv_reset_wdt
    import supv_pkg::*;
#(
    parameter bit ACT_HIGH = 1'b0,
    parameter int HOLD_CYC = 62_500_000,
    parameter int WD_SHORT = 25_000_000,
    parameter int WD_MED   = 100_000_000,
    parameter int WD_LONG  = 350_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_low,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       rst_o
);
    localparam int             HCW       = $clog2(HOLD_CYC + 1);
    localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

    supv_st_e       st, st_nxt;
    logic [HCW-1:0] hcnt;
    logic           start;
    logic           bite;
    logic           rst_act;

    supv_start_det #(.SYNC_STAGES(2)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start)
    );

    supv_wdog #(
        .WD_SHORT (WD_SHORT),
        .WD_MED   (WD_MED),
        .WD_LONG  (WD_LONG)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (st == ST_RUN),
        .wd_en  (wd_en),
        .wd_sel (wd_sel),
        .kick   (start),
        .bite   (bite)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_LOW:  st_nxt = supply_low ? ST_LOW : ST_HOLD;
            ST_HOLD: begin
                if (supply_low)             st_nxt = ST_LOW;
                else if (hcnt == HOLD_LAST) st_nxt = ST_RUN;
                else                        st_nxt = ST_HOLD;
            end
            ST_RUN: begin
                if (supply_low) st_nxt = ST_LOW;
                else if (bite)  st_nxt = ST_HOLD;
                else            st_nxt = ST_RUN;
            end
            default: st_nxt = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_HOLD;
            hcnt <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_HOLD && st_nxt == ST_HOLD) hcnt <= hcnt + HCW'(1);
            else                                    hcnt <= '0;
        end
    end

    always_comb begin
        rst_act = (st != ST_RUN);
        rst_o   = ACT_HIGH ? rst_act : ~rst_act;
    end

    AST_LOW_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_act) else $error("low not reset");   // R1
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt < HCW'(HOLD_CYC)) else $error("hold overrun");      // R2
    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> ($past(hcnt) == HOLD_LAST)) else $error("early"); // R2
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_act) |-> ($past(supply_low) || $past(bite))) else $error("cause"); // R6
endmodule

// File: tb/supv_reset_wdt_tb.sv
module supv_reset_wdt_tb;
    localparam int HOLD = 40;
    localparam int WS   = 30;
    localparam int WM   = 60;
    localparam int WL   = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vlow = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       en = 1'b1;
    logic [1:0] sel = 2'd1;
    logic       rst_lo;
    logic       rst_hi;
    int         checks = 0;
    int         errors = 0;
    int         pol_bad = 0;

    always #2 clk = ~clk;

    supv_reset_wdt #(.ACT_HIGH(1'b0), .HOLD_CYC(HOLD), .WD_SHORT(WS),
        .WD_MED(WM), .WD_LONG(WL)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_low(vlow), .scl_i(scl), .sda_i(sda),
        .wd_en(en), .wd_sel(sel), .rst_o(rst_lo));

    supv_reset_wdt #(.ACT_HIGH(1'b1), .HOLD_CYC(HOLD), .WD_SHORT(WS),
        .WD_MED(WM), .WD_LONG(WL)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .supply_low(vlow), .scl_i(scl), .sda_i(sda),
        .wd_en(en), .wd_sel(sel), .rst_o(rst_hi));

    always @(negedge clk) if (rst_hi !== ~rst_lo) pol_bad++;

    function automatic int lim_of(logic [1:0] s);
        case (s)
            2'd1:    return WS;
            2'd2:    return WM;
            2'd3:    return WL;
            default: return 0;
        endcase
    endfunction

    function automatic bit asserted();
        return (rst_lo == 1'b0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_until(input bit want, input int maxc, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (asserted() != want && n < maxc);
    endtask

    task automatic stay_free(input int cyc, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (asserted()) hit = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit hit;
        void'($urandom(32'd4711));

        // R3: reset asserted while logic reset is held
        repeat (3) @(negedge clk);
        check(asserted(), "R3 reset during rst_n", int'(rst_lo), 0);
        check(rst_hi == 1'b1, "R10 active-high asserted", int'(rst_hi), 1);

        // R3: power-up hold
        rst_n = 1'b1;
        count_until(1'b0, 1000, n);
        check(n == HOLD, "R3 power-up hold", n, HOLD);
        check(rst_hi == 1'b0, "R10 active-high released", int'(rst_hi), 0);

        // R6 + R8: bite at short limit, hold, then restart from zero
        count_until(1'b1, 1000, n);
        check(n == WS, "R6 short timeout", n, WS);
        count_until(1'b0, 1000, n);
        check(n == HOLD, "R8 watchdog reset length", n, HOLD);
        count_until(1'b1, 1000, n);
        check(n == WS, "R8 restart from zero", n, WS);

        for (int s = 2; s <= 3; s++) begin
            sel = 2'(s);
            count_until(1'b0, 1000, n);
            check(n == HOLD, "R8 hold", n, HOLD);
            count_until(1'b1, 1000, n);
            check(n == lim_of(2'(s)), "R6 selected timeout", n, lim_of(2'(s)));
        end

        // R7: enable cleared
        en = 1'b0;
        count_until(1'b0, 1000, n);
        stay_free(3 * WL, hit);
        check(!hit, "R7 disabled never bites", int'(hit), 0);

        // R6: code 0 disables
        en = 1'b1;
        sel = 2'd0;
        stay_free(3 * WL, hit);
        check(!hit, "R6 code 0 disabled", int'(hit), 0);

        // R9: change of select restarts
        sel = 2'd1;
        count_until(1'b1, 1000, n);
        check(n == WS + 1, "R9 select change", n, WS + 1);
        count_until(1'b0, 1000, n);
        stay_free(10, hit);
        sel = 2'd2;
        count_until(1'b1, 1000, n);
        check(n == WM + 1, "R9 select change mid-count", n, WM + 1);
        count_until(1'b0, 1000, n);

        // R4: random START kicks keep reset away
        hit = 1'b0;
        for (int k = 0; k < 25; k++) begin
            bit h;
            sda = 1'b0;
            stay_free(2, h);
            hit |= h;
            sda = 1'b1;
            stay_free($urandom_range(WS - 10, 1), h);
            hit |= h;
        end
        check(!hit, "R4 kicks prevent reset", int'(hit), 0);
        sda = 1'b0;
        count_until(1'b1, 1000, n);
        check(n == WM + 3, "R4 bite after last START", n, WM + 3);
        sda = 1'b1;
        count_until(1'b0, 1000, n);

        // R5: SDA activity with SCL low does not restart
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 2) scl = 1'b0;
            else if (n >= 3 && n <= 10) sda = 1'($urandom_range(1, 0));
            else if (n == 11) sda = 1'b1;
            else if (n == 12) scl = 1'b1;
        end while (!asserted() && n < 1000);
        check(n == WM, "R5 SCL-low toggles ignored", n, WM);
        count_until(1'b0, 1000, n);

        // R1 + R2: random supply dips
        for (int k = 0; k < 4; k++) begin
            int d = $urandom_range(20, 5);
            stay_free($urandom_range(15, 1), hit);
            vlow = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(asserted(), "R1 supply low asserts", int'(rst_lo), 0);
            hit = 1'b1;
            for (int i = 0; i < d; i++) begin
                @(negedge clk);
                if (!asserted()) hit = 1'b0;
            end
            check(hit, "R1 held while low", int'(hit), 1);
            vlow = 1'b0;
            count_until(1'b0, 1000, n);
            check(n == HOLD + 1, "R2 recovery hold", n, HOLD + 1);
        end

        // R3: power-up with supply low
        rst_n = 1'b0;
        vlow = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        stay_free(5, hit);
        check(asserted(), "R3 low at power-up", int'(rst_lo), 0);
        vlow = 1'b0;
        count_until(1'b0, 1000, n);
        check(n == HOLD + 1, "R3 power-up recovery", n, HOLD + 1);
        count_until(1'b1, 1000, n);
        check(n == WM, "R8 counter cleared during reset", n, WM);

        check(pol_bad == 0, "R10 polarity mismatch count", pol_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule